// File: doc/BRIEF.md
# Saturating Vector Lane Narrower

This block halves the width of every lane of a 64-bit source vector and packs the narrowed lanes into a 32-bit result. A two-bit element-size selector sets the lane split. Four 16-bit lanes can become four bytes. Two 32-bit lanes can become two halfwords. The whole 64-bit word can become one 32-bit word.

Two decode inputs choose how each lane is reduced:
- plain truncation;
- signed-to-signed saturation;
- unsigned-to-unsigned saturation;
- signed-source to unsigned-destination saturation.

In the last mode, negative lanes become zero and positive lanes beyond the destination range become all-ones.

Every clamp raises a sticky saturation flag. The flag collects clamps across lanes and across successive operations, and stays set until a dedicated clear input or reset. The block has no handshake: the inputs are sampled on every rising clock edge, and the result, error and flag are registered at that edge.

Top module: `simd_narrow_sat`

## Requirements
- R1: While rst_ni is low, res_o, size_err_o and sat_o are all 0.
- R2: The res_o and size_err_o values produced by the inputs sampled at a rising edge appear right after that edge and hold until the next edge.
- R3: Lane packing depends on size_i.
  - size_i=0: the source halfwords at bit offsets 0, 16, 32 and 48 produce res_o bytes [7:0], [15:8], [23:16] and [31:24].
  - size_i=1: the source bits [31:0] produce res_o[15:0], and the source bits [63:32] produce res_o[31:16].
  - size_i=2: the whole source is one lane.
- R4: Mode decode is {sat_op_i, q_i}: 00 is truncation, 01 is signed-to-unsigned, 10 is signed-to-signed, and 11 is unsigned-to-unsigned.
- R5: Truncation keeps the low half of each lane and never sets the flag.
- R6: Signed-to-signed saturation clamps a lane outside the destination's signed range to its most negative or most positive value, and sets the flag.
- R7: Unsigned-to-unsigned saturation clamps a lane above the destination's unsigned maximum to all-ones, and sets the flag.
- R8: In signed-to-unsigned mode, a lane with its sign bit set gives 0 and sets the flag.
- R9: In signed-to-unsigned mode, a non-negative lane above the unsigned maximum (0xFF, 0xFFFF or 0xFFFFFFFF) gives all-ones and sets the flag.
- R10: In signed-to-unsigned mode, an in-range lane passes its low half unchanged and does not set the flag.
- R11: sat_o is the OR of all lane clamps of all operations since the last clear or reset. Once set, it stays set while sat_clr_i is low.
- R12: When sat_clr_i is high at an edge, the old flag value is discarded, and the flag is set only if the operation sampled at that same edge clamps.
- R13: size_i=3 gives res_o=0 and size_err_o=1 for that result cycle, and the operation adds nothing to the flag. size_err_o is 0 for any legal size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Source vector |
| size_i | input | 2 | Destination element size: 0=8, 1=16, 2=32, 3=illegal |
| sat_op_i | input | 1 | 0 selects the narrow operation, 1 selects the saturating-narrow operation |
| q_i | input | 1 | Variant bit within the selected operation |
| sat_clr_i | input | 1 | Clears the sticky saturation flag |
| res_o | output | 32 | Packed narrowed result |
| size_err_o | output | 1 | Illegal size seen for this result |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The result, the size error and the flag update all become visible one edge after their inputs are sampled. No output has a second register stage. The bench changes its inputs on the falling edge and checks on the following falling edge, so every check sees exactly one capturing edge. Flag history checks walk several operations in a row without clearing. They confirm that the flag holds across non-clamping and illegal operations, and that a clear in the same cycle as a clamping operation still leaves the flag set.

// File: rtl/simd_narrow_pkg.sv
package simd_narrow_pkg;
  localparam int unsigned SRC_W     = 64;
  localparam int unsigned RES_W     = SRC_W / 2;
  localparam int unsigned BASE_LW   = 8;
  localparam int unsigned NUM_SIZES = 3;
  localparam int unsigned SZ_W      = 2;

  typedef enum logic [1:0] {
    NM_TRUNC = 2'b00,
    NM_S2U   = 2'b01,
    NM_S2S   = 2'b10,
    NM_U2U   = 2'b11
  } narrow_mode_e;
endpackage

// File: rtl/narrow_lane.sv
module narrow_lane
  import simd_narrow_pkg::*;
#(
  parameter int unsigned OUT_W = 8,
  localparam int unsigned IN_W = 2 * OUT_W
) (
  input  logic [IN_W-1:0]  lane_i,
  input  narrow_mode_e     mode_i,
  output logic [OUT_W-1:0] lane_o,
  output logic             sat_o
);
  localparam logic [OUT_W-1:0] ALL_ONES = '1;
  localparam logic [OUT_W-1:0] S_MAX    = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] S_MIN    = {1'b1, {(OUT_W-1){1'b0}}};

  logic [OUT_W-1:0] low;
  logic             neg;
  logic             s_fits;
  logic             u_hi_set;
  logic             s2u_hi_set;

  assign low        = lane_i[OUT_W-1:0];
  assign neg        = lane_i[IN_W-1];
  // signed fit: bits above the destination sign all copy it
  assign s_fits     = (&lane_i[IN_W-1:OUT_W-1]) | ~(|lane_i[IN_W-1:OUT_W-1]);
  assign u_hi_set   = |lane_i[IN_W-1:OUT_W];
  assign s2u_hi_set = |lane_i[IN_W-2:OUT_W];

  always_comb begin
    lane_o = low;
    sat_o  = 1'b0;
    unique case (mode_i)
      NM_TRUNC: ;
      NM_S2S: if (!s_fits) begin
        lane_o = neg ? S_MIN : S_MAX;
        sat_o  = 1'b1;
      end
      NM_U2U: if (u_hi_set) begin
        lane_o = ALL_ONES;
        sat_o  = 1'b1;
      end
      NM_S2U: if (neg) begin
        lane_o = '0;
        sat_o  = 1'b1;
      end else if (s2u_hi_set) begin
        lane_o = ALL_ONES;
        sat_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/narrow_group.sv
module narrow_group
  import simd_narrow_pkg::*;
#(
  parameter int unsigned OUT_LW = 8,
  parameter int unsigned GSRC_W = SRC_W,
  localparam int unsigned IN_LW  = 2 * OUT_LW,
  localparam int unsigned GRES_W = GSRC_W / 2,
  localparam int unsigned NL     = GSRC_W / IN_LW
) (
  input  logic [GSRC_W-1:0] src_i,
  input  narrow_mode_e      mode_i,
  output logic [GRES_W-1:0] res_o,
  output logic              sat_o
);
  logic [NL-1:0] lane_sat;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    narrow_lane #(.OUT_W(OUT_LW)) u_lane (
      .lane_i (src_i[l*IN_LW +: IN_LW]),
      .mode_i (mode_i),
      .lane_o (res_o[l*OUT_LW +: OUT_LW]),
      .sat_o  (lane_sat[l])
    );
  end

  assign sat_o = |lane_sat;
endmodule

// File: rtl/simd_narrow_sat.sv
module simd_narrow_sat
  import simd_narrow_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] src_i,
  input  logic [SZ_W-1:0]  size_i,
  input  logic             sat_op_i,
  input  logic             q_i,
  input  logic             sat_clr_i,
  output logic [RES_W-1:0] res_o,
  output logic             size_err_o,
  output logic             sat_o
);
  narrow_mode_e     mode;
  logic [RES_W-1:0] grp_res [NUM_SIZES];
  logic             grp_sat [NUM_SIZES];
  logic [RES_W-1:0] res_d;
  logic             sat_hit;
  logic             size_bad;

  assign mode = narrow_mode_e'({sat_op_i, q_i});

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    narrow_group #(.OUT_LW(BASE_LW << s), .GSRC_W(SRC_W)) u_grp (
      .src_i  (src_i),
      .mode_i (mode),
      .res_o  (grp_res[s]),
      .sat_o  (grp_sat[s])
    );
  end

  always_comb begin
    res_d    = '0;
    sat_hit  = 1'b0;
    size_bad = 1'b1;
    for (int s = 0; s < NUM_SIZES; s++) begin
      if (size_i == SZ_W'(s)) begin
        res_d    = grp_res[s];
        sat_hit  = grp_sat[s];
        size_bad = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o      <= '0;
      size_err_o <= 1'b0;
      sat_o      <= 1'b0;
    end else begin
      res_o      <= res_d;
      size_err_o <= size_bad;
      sat_o      <= (sat_o & ~sat_clr_i) | sat_hit;
    end
  end
endmodule

// File: rtl/simd_narrow_sat_chk.sv
module simd_narrow_sat_chk
  import simd_narrow_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SRC_W-1:0] src_i,
  input logic [SZ_W-1:0]  size_i,
  input logic             sat_op_i,
  input logic             q_i,
  input logic             sat_clr_i,
  input logic [RES_W-1:0] res_o,
  input logic             size_err_o,
  input logic             sat_o
);
  a_r13_illegal_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'd3) |=> (size_err_o && res_o == '0));

  a_r13_legal_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i != 2'd3) |=> !size_err_o);

  a_r13_flag_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'd3 && !sat_clr_i) |=> (sat_o == $past(sat_o)));

  a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o && !sat_clr_i) |=> sat_o);

  a_r5_trunc_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sat_op_i && !q_i && !sat_clr_i) |=> (sat_o == $past(sat_o)));

  a_r8_s2u_negative: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sat_op_i && q_i && size_i == 2'd2 && src_i[SRC_W-1]) |=> (res_o == '0 && sat_o));

  a_r9_s2u_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sat_op_i && q_i && size_i == 2'd2 && !src_i[SRC_W-1] && (|src_i[SRC_W-2:RES_W]))
    |=> (res_o == '1 && sat_o));
endmodule

bind simd_narrow_sat simd_narrow_sat_chk u_chk (.*);

// File: tb/tb_simd_narrow_sat.sv
`timescale 1ns/1ps
module tb_simd_narrow_sat;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src_i = '0;
  logic [1:0]  size_i = '0;
  logic        sat_op_i = 1'b0;
  logic        q_i = 1'b0;
  logic        sat_clr_i = 1'b0;
  logic [31:0] res_o;
  logic        size_err_o;
  logic        sat_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  simd_narrow_sat dut (.*);

  typedef struct packed {
    logic [63:0] src;
    logic [1:0]  size;
    logic        op;
    logic        q;
    logic [31:0] res;
    logic        sat;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{64'h1234_5678_9ABC_DEF0, 2'd0, 1'b0, 1'b0, 32'h3478_BCF0, 1'b0, 8'd5},  // R5 R3
    '{64'h1234_5678_9ABC_DEF0, 2'd1, 1'b0, 1'b0, 32'h5678_DEF0, 1'b0, 8'd5},  // R5
    '{64'h1234_5678_9ABC_DEF0, 2'd2, 1'b0, 1'b0, 32'h9ABC_DEF0, 1'b0, 8'd5},  // R5
    '{64'h8000_0000_0000_0000, 2'd2, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 8'd5},  // R5
    '{64'h00FF_007F_0100_8000, 2'd0, 1'b0, 1'b1, 32'hFF7F_FF00, 1'b1, 8'd8},  // R8 R9 R3
    '{64'h0012_0000_00FF_0001, 2'd0, 1'b0, 1'b1, 32'h1200_FF01, 1'b0, 8'd10}, // R10
    '{64'h0000_FFFF_FFFF_FFFF, 2'd1, 1'b0, 1'b1, 32'hFFFF_0000, 1'b1, 8'd8},  // R8
    '{64'h0001_0000_0000_1234, 2'd1, 1'b0, 1'b1, 32'hFFFF_1234, 1'b1, 8'd9},  // R9
    '{64'h8000_0000_0000_0005, 2'd2, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 8'd8},  // R8
    '{64'h0000_0001_0000_0000, 2'd2, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 8'd9},  // R9
    '{64'h0000_0000_FFFF_FFFF, 2'd2, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 8'd10}, // R10
    '{64'hFF7F_FF80_0080_007F, 2'd0, 1'b1, 1'b0, 32'h8080_7F7F, 1'b1, 8'd6},  // R6 R4
    '{64'h0000_7FFF_FFFF_8000, 2'd1, 1'b1, 1'b0, 32'h7FFF_8000, 1'b0, 8'd6},  // R6
    '{64'hFFFF_FFFF_7FFF_FFFF, 2'd2, 1'b1, 1'b0, 32'h8000_0000, 1'b1, 8'd6},  // R6
    '{64'h0100_0001_00FF_8000, 2'd0, 1'b1, 1'b1, 32'hFF01_FFFF, 1'b1, 8'd7},  // R7 R4
    '{64'h0000_ABCD_0000_FFFF, 2'd1, 1'b1, 1'b1, 32'hABCD_FFFF, 1'b0, 8'd7},  // R7
    '{64'h1000_0000_0000_0000, 2'd2, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 8'd7}   // R7
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // inputs change at a falling edge; result checked at the next falling edge
  task automatic step(input logic [63:0] s, input logic [1:0] sz,
                      input logic op, input logic q, input logic clr);
    src_i = s; size_i = sz; sat_op_i = op; q_i = q; sat_clr_i = clr;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", "res in reset", res_o, 32'h0);
    check("R1", "err in reset", {31'h0, size_err_o}, 32'h0);
    check("R1", "sat in reset", {31'h0, sat_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].src, VECS[i].size, VECS[i].op, VECS[i].q, 1'b1);
      check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d res", i), res_o, VECS[i].res);
      check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d sat", i),
            {31'h0, sat_o}, {31'h0, VECS[i].sat});
    end

    // R2: output unchanged before the capturing edge
    step(64'h0000_0000_0000_0011, 2'd2, 1'b0, 1'b0, 1'b1);
    src_i = 64'h0000_0000_0000_0022;
    @(posedge clk_i); #1;
    check("R2", "after edge", res_o, 32'h22);
    src_i = 64'h0000_0000_0000_0033;
    @(negedge clk_i); #1;
    check("R2", "held between edges", res_o, 32'h22);
    @(negedge clk_i);

    // R11: sticky across lanes and operations
    step(64'h0000_0000_0000_0000, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R12", "clear with no clamp", {31'h0, sat_o}, 32'h0);
    step(64'h0000_0000_0000_0100, 2'd0, 1'b1, 1'b1, 1'b0);
    check("R11", "set by clamp", {31'h0, sat_o}, 32'h1);
    step(64'h0000_0000_0000_0001, 2'd1, 1'b0, 1'b1, 1'b0);
    check("R11", "held over clean op", {31'h0, sat_o}, 32'h1);
    step(64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 1'b0, 1'b0, 1'b0);
    check("R11", "held over truncation", {31'h0, sat_o}, 32'h1);

    // R13: illegal size, flag kept
    step(64'h8000_0000_0000_0000, 2'd3, 1'b0, 1'b1, 1'b0);
    check("R13", "illegal res", res_o, 32'h0);
    check("R13", "illegal err", {31'h0, size_err_o}, 32'h1);
    check("R13", "illegal keeps set flag", {31'h0, sat_o}, 32'h1);
    step(64'h0, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R13", "err drops on legal", {31'h0, size_err_o}, 32'h0);
    check("R12", "clear", {31'h0, sat_o}, 32'h0);
    step(64'h8000_0000_0000_0000, 2'd3, 1'b0, 1'b1, 1'b0);
    check("R13", "illegal adds no flag", {31'h0, sat_o}, 32'h0);

    // R12: clear and clamp in the same cycle leaves the flag set
    step(64'h0000_0000_0000_0100, 2'd0, 1'b1, 1'b1, 1'b0);
    step(64'h0000_0000_8000_0000, 2'd1, 1'b0, 1'b1, 1'b1);
    check("R12", "clear with clamp", {31'h0, sat_o}, 32'h1);
    check("R8", "clear cycle res", res_o, 32'h0);

    // R11: clamp in one lane only among many
    step(64'h0, 2'd0, 1'b0, 1'b0, 1'b1);
    step(64'h0100_0000_0000_0000, 2'd0, 1'b0, 1'b1, 1'b1);
    check("R11", "top lane clamp", {31'h0, sat_o}, 32'h1);
    check("R3", "top lane byte", res_o, 32'hFF00_0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule